// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one multi-register memory transfer. A host pulses `start` with a 32-bit transfer word and the current value of the base register. The sequencer then walks the 16-bit register selection mask. For each selected register it issues one word-sized memory request, and for each load it writes the returned word into the register file. A pick circuit chooses the next register from the bits not yet served, so registers whose mask bit is clear cost no cycle and do not move the address.

The transfer word sets five things: the direction (addresses rise and registers go lowest first, or addresses fall and registers go highest first), whether the 4-byte step comes before or after each access, load or store, and whether the final address is written back to the base register. A mask that selects the highest register, or a set reserved bit, makes the block raise `undef` and do nothing else. An empty mask finishes at once, with only the optional base update.

Top module: `block_xfer_seq`

## Requirements
- R1: Field positions in `instr`: [15:0] register mask, [19:16] base register index, [20] load (1) or store (0), [21] base writeback, [22] reserved, [23] direction (1 up), [24] step-before (1) or step-after (0).
- R2: When bit 23 is 1, selected registers are served in order 0 upward. When bit 23 is 0, they are served from 15 downward. Each selected register gets exactly one access, and unselected registers get none.
- R3: Each access moves the address by 4, up or down. With bit 24 set, the first access is at base±4. With bit 24 clear, the first access is at base. Every later access is 4 beyond the previous one.
- R4: A store drives `mem_we`=1 and `mem_wdata` equal to `rf_rd_data` for the register shown on `rf_rd_idx`. A load drives `mem_we`=0, and in the accepting cycle it writes `mem_rdata` to that register through `rf_wr_en`/`rf_wr_idx`/`rf_wr_data`.
- R5: While `mem_ready` is low, the request stays asserted with the same address and direction.
- R6: With bit 21 set, the cycle after the last access writes the final address (base ± 4·count) to the base register index. With bit 21 clear, no base write occurs.
- R7: If mask bit 15 or bit 22 is set, `undef` pulses for one cycle, one cycle after `start`. No memory request, register write or `done` follows.
- R8: An empty mask produces no memory access. The optional base write comes in the cycle after `start`, and `done` follows one cycle later.
- R9: `done` is a one-cycle pulse in the cycle after the writeback slot. `busy` is high from the cycle after `start` through the writeback slot.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, `mem_req`, `rf_wr_en`, `done` and `undef` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| instr | input | 32 | Transfer word |
| base_val | input | 32 | Current base register value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| undef | output | 1 | Rejected transfer pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts/completes request this cycle |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |

## Verification
The first memory request appears in the cycle after `start` is taken. Each request completes in the cycle where `mem_ready` is high, and any load write lands in that same cycle. The base write takes the single cycle after the last completion (or after `start` for an empty mask), `done` follows one cycle later, and `undef` comes one cycle after `start`. A driver task predicts these events in order into a scoreboard queue. A monitor samples at the falling clock edge and pops one entry per observed event, so an early, late, extra or missing event shows up as a mismatch. The memory ready line follows an irregular stall pattern, so the checks cover both held and immediately accepted requests.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    localparam int NREG  = 16;
    localparam int IDXW  = $clog2(NREG);
    localparam int IW    = 32;
    localparam int STEP  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WB   = 2'd2
    } bxs_state_e;

    typedef struct packed {
        logic            pre;
        logic            up;
        logic            rsvd;
        logic            wback;
        logic            load;
        logic [IDXW-1:0] base_idx;
        logic [NREG-1:0] mask;
    } bxs_op_t;

    function automatic bxs_op_t bxs_decode(input logic [IW-1:0] w);
        bxs_op_t o;
        o.mask     = w[15:0];
        o.base_idx = w[19:16];
        o.load     = w[20];
        o.wback    = w[21];
        o.rsvd     = w[22];
        o.up       = w[23];
        o.pre      = w[24];
        return o;
    endfunction

    function automatic logic bxs_illegal(input bxs_op_t o);
        return o.rsvd | o.mask[NREG-1];
    endfunction

endpackage

// File: rtl/bxs_pick.sv
module bxs_pick
    import bxs_pkg::*;
#(
    parameter int N  = NREG,
    parameter int XW = $clog2(N)
) (
    input  logic [N-1:0]  pending,
    input  logic          up,
    output logic [XW-1:0] idx,
    output logic          any
);
    logic [XW-1:0] lo_idx, hi_idx;

    always_comb begin
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) lo_idx = XW'(i);
        end
    end

    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (pending[i]) hi_idx = XW'(i);
        end
    end

    assign idx = up ? lo_idx : hi_idx;
    assign any = |pending;
endmodule

// File: rtl/bxs_addr.sv
module bxs_addr
    import bxs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic          up,
    input  logic          pre,
    output logic [AW-1:0] access,
    output logic [AW-1:0] next
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    assign next   = up ? (cur + STEP_V) : (cur - STEP_V);
    assign access = pre ? next : cur;
endmodule

// File: rtl/block_xfer_seq.sv
module block_xfer_seq
    import bxs_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IW-1:0]   instr,
    input  logic [AW-1:0]   base_val,
    output logic            busy,
    output logic            done,
    output logic            undef,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ready,
    input  logic [DW-1:0]   mem_rdata,
    output logic [IDXW-1:0] rf_rd_idx,
    input  logic [DW-1:0]   rf_rd_data,
    output logic            rf_wr_en,
    output logic [IDXW-1:0] rf_wr_idx,
    output logic [DW-1:0]   rf_wr_data
);
    bxs_state_e      state;
    bxs_op_t         op_q;
    bxs_op_t         op_in;
    logic [NREG-1:0] remain;
    logic [NREG-1:0] remain_nx;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   acc_addr;
    logic [AW-1:0]   nxt_addr;
    logic [IDXW-1:0] sel;
    logic            pending;
    logic            done_q;
    logic            undef_q;
    logic            fire;

    assign op_in = bxs_decode(instr);

    bxs_pick #(.N(NREG), .XW(IDXW)) u_pick (
        .pending (remain),
        .up      (op_q.up),
        .idx     (sel),
        .any     (pending)
    );

    bxs_addr #(.AW(AW)) u_addr (
        .cur    (addr_q),
        .up     (op_q.up),
        .pre    (op_q.pre),
        .access (acc_addr),
        .next   (nxt_addr)
    );

    assign remain_nx = remain & ~(NREG'(1) << sel);
    assign fire      = (state == ST_XFER) && pending && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= '0;
            remain  <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
            undef_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            undef_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (bxs_illegal(op_in)) begin
                            undef_q <= 1'b1;
                        end else begin
                            op_q   <= op_in;
                            remain <= op_in.mask;
                            addr_q <= base_val;
                            state  <= (|op_in.mask) ? ST_XFER : ST_WB;
                        end
                    end
                end
                ST_XFER: begin
                    if (fire) begin
                        addr_q <= nxt_addr;
                        remain <= remain_nx;
                        if (remain_nx == '0) state <= ST_WB;
                    end
                end
                ST_WB: begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        done       = done_q;
        undef      = undef_q;
        mem_req    = (state == ST_XFER) && pending;
        mem_we     = ~op_q.load;
        mem_addr   = acc_addr;
        rf_rd_idx  = sel;
        mem_wdata  = rf_rd_data;
        rf_wr_en   = 1'b0;
        rf_wr_idx  = sel;
        rf_wr_data = mem_rdata;
        if (state == ST_WB) begin
            rf_wr_en   = op_q.wback;
            rf_wr_idx  = op_q.base_idx;
            rf_wr_data = addr_q;
        end else if (fire && op_q.load) begin
            rf_wr_en   = 1'b1;
        end
    end
endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          undef,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          rf_wr_en
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R5
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        undef |-> !mem_req && !rf_wr_en && !done && !busy); // R7
    AST_UNDEF_PULSE: assert property (@(posedge clk) disable iff (rst)
        undef |=> !undef && !busy); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R9
    AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready && !mem_we |-> rf_wr_en); // R4
    AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !rf_wr_en); // R4
endmodule

bind block_xfer_seq bxs_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .undef     (undef),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .rf_wr_en  (rf_wr_en)
);

// File: tb/block_xfer_seq_tb.sv
module block_xfer_seq_tb;
    import bxs_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic        busy, done, undef, mem_req, mem_we, rf_wr_en;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
    logic        mem_ready = 1'b0;
    logic [3:0]  rf_rd_idx, rf_wr_idx;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rdy_mode = 0;

    typedef struct {
        int          kind;   // 0 mem access, 1 base write, 2 done, 3 undef
        logic [31:0] addr;
        logic        we;
        logic [31:0] data;
        logic [3:0]  idx;
        string       req;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    block_xfer_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .base_val(base_val),
        .busy(busy), .done(done), .undef(undef),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
    );

    assign rf_rd_data = 32'hC000_0000 + 32'(rf_rd_idx);
    assign mem_rdata  = mem_addr ^ 32'h5A5A_5A5A;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        mem_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 1);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit pre, bit up, bit rsv, bit wb, bit ld,
                                       logic [3:0] b, logic [15:0] m);
        return {7'b0, pre, up, rsv, wb, ld, b, m};
    endfunction

    // driver: predicts the event sequence, then issues the start pulse
    task automatic run_op(input logic [31:0] w, input logic [31:0] base, input string req);
        bxs_op_t o = bxs_decode(w);
        logic [31:0] a = base;
        exp_t e;
        if (o.rsvd || o.mask[15]) begin
            e = '{3, 0, 0, 0, 0, {req, "/R7"}};
            q.push_back(e);
        end else begin
            for (int k = 0; k < 16; k++) begin
                int i = o.up ? k : 15 - k;
                if (o.mask[i]) begin
                    if (o.pre) a = o.up ? a + 4 : a - 4;
                    e = '{0, a, !o.load, 32'hC000_0000 + 32'(i), 4'(i), {req, "/R2/R3/R4"}};
                    q.push_back(e);
                    if (!o.pre) a = o.up ? a + 4 : a - 4;
                end
            end
            if (o.wback) begin
                e = '{1, 0, 0, a, o.base_idx, {req, "/R6"}};
                q.push_back(e);
            end
            e = '{2, 0, 0, 0, 0, {req, "/R9"}};
            q.push_back(e);
        end
        @(posedge clk); #1;
        start = 1'b1; instr = w; base_val = base;
        @(posedge clk); #1;
        start = 1'b0;
        wait (q.size() == 0);
        repeat (3) @(negedge clk);
        chk(!busy, "R9", "busy after completion", 32'(busy), 0);
    endtask

    // monitor: pops one expected entry per observed event
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr  = '0;
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (prev_stall)
                chk(mem_req && mem_addr == prev_addr, "R5", "held request addr", mem_addr, prev_addr);
            prev_stall = mem_req && !mem_ready;
            prev_addr  = mem_addr;
            if (mem_req && mem_ready) begin
                if (q.size() == 0) chk(0, "R2", "unexpected access", mem_addr, 0);
                else begin
                    e = q.pop_front();
                    chk(e.kind == 0, e.req, "event kind (access)", 0, 32'(e.kind));
                    chk(mem_addr == e.addr, e.req, "access address", mem_addr, e.addr);
                    chk(mem_we == e.we, e.req, "access direction", 32'(mem_we), 32'(e.we));
                    if (e.we) chk(mem_wdata == e.data && !rf_wr_en, e.req, "store data", mem_wdata, e.data);
                    else chk(rf_wr_en && rf_wr_idx == e.idx && rf_wr_data == (e.addr ^ 32'h5A5A_5A5A),
                             e.req, "load write", {28'b0, rf_wr_idx}, {28'b0, e.idx});
                end
            end else if (rf_wr_en) begin
                if (q.size() == 0) chk(0, "R6", "unexpected reg write", rf_wr_data, 0);
                else begin
                    e = q.pop_front();
                    chk(e.kind == 1, e.req, "event kind (base write)", 1, 32'(e.kind));
                    chk(rf_wr_idx == e.idx && rf_wr_data == e.data, e.req, "base writeback", rf_wr_data, e.data);
                end
            end
            if (done) begin
                if (q.size() == 0) chk(0, "R9", "unexpected done", 1, 0);
                else begin
                    e = q.pop_front();
                    chk(e.kind == 2, e.req, "event kind (done)", 2, 32'(e.kind));
                end
            end
            if (undef) begin
                if (q.size() == 0) chk(0, "R7", "unexpected undef", 1, 0);
                else begin
                    e = q.pop_front();
                    chk(e.kind == 3, e.req, "event kind (undef)", 3, 32'(e.kind));
                end
            end
        end
    end

    initial begin
        #2_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired, pending=%0d expected=0", q.size());
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !rf_wr_en && !done && !undef, "R11", "reset outputs",
            {27'b0, busy, mem_req, rf_wr_en, done, undef}, 0);

        // R1 R2 R3: up, step-after, store, writeback
        run_op(mk(0, 1, 0, 1, 0, 4'd3, 16'h00F1), 32'h0000_1000, "R1");
        // down, step-before, load, writeback, with stalls
        rdy_mode = 1;
        run_op(mk(1, 0, 0, 1, 1, 4'd13, 16'h4182), 32'h0000_2000, "R2");
        // up, step-before, load, no writeback (R6 clear)
        run_op(mk(1, 1, 0, 0, 1, 4'd1, 16'h0A05), 32'h0000_3000, "R3");
        // down, step-after, store, writeback, stalls (R5)
        run_op(mk(0, 0, 0, 1, 0, 4'd2, 16'h7FFF), 32'h0000_4000, "R5");
        rdy_mode = 0;
        // base inside mask on load with writeback: base write lands last
        run_op(mk(0, 1, 0, 1, 1, 4'd4, 16'h0031), 32'h0000_5000, "R6");
        // empty mask, with and without writeback
        run_op(mk(1, 1, 0, 1, 0, 4'd7, 16'h0000), 32'h0000_6000, "R8");
        run_op(mk(0, 0, 0, 0, 1, 4'd7, 16'h0000), 32'h0000_6000, "R8");
        // rejected words: top mask bit, reserved bit
        run_op(mk(0, 1, 0, 1, 1, 4'd0, 16'h8001), 32'h0000_7000, "R7");
        run_op(mk(1, 0, 1, 0, 0, 4'd0, 16'h0003), 32'h0000_7000, "R7");

        // R10: a second start while busy must not be taken
        rdy_mode = 1;
        fork
            run_op(mk(0, 1, 0, 1, 0, 4'd5, 16'h0C00), 32'h0000_8000, "R10");
            begin
                repeat (3) @(posedge clk);
                #2;
                chk(busy, "R10", "busy during transfer", 32'(busy), 1);
                start = 1'b1; instr = mk(0, 1, 1, 1, 1, 4'd9, 16'h8FFF);
                @(posedge clk); #2;
                start = 1'b0;
            end
        join
        rdy_mode = 0;

        chk(q.size() == 0, "R9", "scoreboard drained", 32'(q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule